// File: doc/BRIEF.md
# Highway and Farm-Road Crossing Light Controller

This block sequences the lamps at a crossing where a busy highway meets a rarely used farm road. The highway keeps green by default. A car sensor on the farm road asks for service. The controller grants it only after the highway has held green for a minimum interval. The farm road then gets green for as long as a car is still sensed, up to a maximum interval. Both yellow phases last a fixed short interval.

A control machine drives the lamps, and each lamp depends only on the current phase. A small interval timer measures the time spent in each phase. The machine raises a restart strobe in the cycle before every phase change, and this strobe depends on the current inputs. The timer clears on the strobe and reports two sticky flags, one for the short interval and one for the long interval. Reset puts the crossing in highway green and clears the timer, so the minimum highway green also applies right after reset.

Top module: `traffic_crossing_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, the highway shows green and the farm road shows red, and the timer starts from zero.
- R2: Highway green changes to highway yellow only on a clock edge where the farm car input is 1 and at least LONG_TICKS edges have passed since the phase began. A highway green phase therefore lasts at least LONG_TICKS+1 cycles.
- R3: Highway yellow lasts exactly SHORT_TICKS+1 cycles and is followed by farm green.
- R4: Farm green changes to farm yellow on the first edge where the farm car input is 0 or LONG_TICKS edges have passed since the phase began. With a car sensed throughout, it lasts LONG_TICKS+1 cycles.
- R5: Farm yellow lasts exactly SHORT_TICKS+1 cycles and is followed by highway green.
- R6: Each road has exactly one lamp lit in every cycle, and at least one road always shows red.
- R7: timerStart is 1 in a cycle exactly when the phase will change at the next edge. It follows the farm car input within the same cycle.
- R8: Once the short-interval or long-interval flag of the timer is set, it stays set until the next restart strobe, which clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| farmCar | input | 1 | 1 while a car waits on the farm road |
| hwyGreen | output | 1 | Highway green lamp |
| hwyYellow | output | 1 | Highway yellow lamp |
| hwyRed | output | 1 | Highway red lamp |
| farmGreen | output | 1 | Farm road green lamp |
| farmYellow | output | 1 | Farm road yellow lamp |
| farmRed | output | 1 | Farm road red lamp |
| timerStart | output | 1 | Timer restart strobe, 1 in the cycle before a phase change |

## Verification
The hardest case to reach is the farm green cut short by the car leaving before the long interval ends, at a chosen offset into the phase. Only the car input controls this, and it first has to pass through the minimum highway green and a full yellow. The bench steers there on purpose: it holds the car through highway green and yellow, then drops it after a known number of farm green cycles. A long random run with bursty car patterns then compares every lamp and strobe against a cycle model kept in the bench.

// File: rtl/xing_pkg.sv
package xing_pkg;

  typedef enum logic [1:0] {
    PH_HWY_GO   = 2'd0,
    PH_HWY_WARN = 2'd1,
    PH_FARM_GO  = 2'd2,
    PH_FARM_WARN = 2'd3
  } phase_t;

  // strobes from control to the interval timer
  typedef struct packed {
    logic restartTimer;
  } ctlStrobes_t;

  // status from the interval timer back to control
  typedef struct packed {
    logic shortDone;
    logic longDone;
  } tmrStatus_t;

endpackage

// File: rtl/xing_timer.sv
module xing_timer
  import xing_pkg::*;
#(
  parameter int SHORT_TICKS = 3,
  parameter int LONG_TICKS  = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  ctlStrobes_t strobes,
  output tmrStatus_t  status
);

  localparam int CNT_W = $clog2(LONG_TICKS + 1);
  localparam logic [CNT_W-1:0] SHORT_C = CNT_W'(SHORT_TICKS);
  localparam logic [CNT_W-1:0] LONG_C  = CNT_W'(LONG_TICKS);

  logic [CNT_W-1:0] tickCount;

  // counter saturates at the long limit so both flags remain set
  always_ff @(posedge clk) begin
    if (rst || strobes.restartTimer) begin
      tickCount <= '0;
    end else if (tickCount != LONG_C) begin
      tickCount <= tickCount + 1'b1;
    end
  end

  always_comb begin
    status.shortDone = (tickCount >= SHORT_C);
    status.longDone  = (tickCount >= LONG_C);
  end

  assert_short_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (status.shortDone && !strobes.restartTimer) |=> status.shortDone);

  assert_long_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (status.longDone && !strobes.restartTimer) |=> status.longDone);

  assert_restart_clears_R8: assert property (@(posedge clk) disable iff (rst)
    strobes.restartTimer |=> (!status.shortDone && !status.longDone));

endmodule

// File: rtl/xing_fsm.sv
module xing_fsm
  import xing_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        farmCar,
  input  tmrStatus_t  status,
  output ctlStrobes_t strobes,
  output logic [2:0]  hwyLamps,   // {green, yellow, red}
  output logic [2:0]  farmLamps   // {green, yellow, red}
);

  phase_t phase, phaseNext;

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_HWY_GO:    if (farmCar && status.longDone)  phaseNext = PH_HWY_WARN;
      PH_HWY_WARN:  if (status.shortDone)            phaseNext = PH_FARM_GO;
      PH_FARM_GO:   if (!farmCar || status.longDone) phaseNext = PH_FARM_WARN;
      PH_FARM_WARN: if (status.shortDone)            phaseNext = PH_HWY_GO;
      default:                                       phaseNext = PH_HWY_GO;
    endcase
  end

  // Mealy strobe: raised in the cycle that precedes any phase change
  always_comb strobes.restartTimer = (phaseNext != phase);

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_HWY_GO;
    else     phase <= phaseNext;
  end

  // Moore lamp decode
  always_comb begin
    hwyLamps  = 3'b001;
    farmLamps = 3'b001;
    unique case (phase)
      PH_HWY_GO:    hwyLamps  = 3'b100;
      PH_HWY_WARN:  hwyLamps  = 3'b010;
      PH_FARM_GO:   farmLamps = 3'b100;
      PH_FARM_WARN: farmLamps = 3'b010;
      default: ;
    endcase
  end

  assert_hold_hwy_green_R2: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_HWY_GO && !(farmCar && status.longDone)) |=> phase == PH_HWY_GO);

  assert_hwy_yellow_exit_R3: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_HWY_WARN && status.shortDone) |=> phase == PH_FARM_GO);

  assert_farm_green_cut_R4: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_FARM_GO && (!farmCar || status.longDone)) |=> phase == PH_FARM_WARN);

  assert_farm_yellow_exit_R5: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_FARM_WARN && status.shortDone) |=> phase == PH_HWY_GO);

  assert_restart_on_change_R7: assert property (@(posedge clk) disable iff (rst)
    strobes.restartTimer |=> phase != $past(phase));

  assert_no_silent_change_R7: assert property (@(posedge clk) disable iff (rst)
    !strobes.restartTimer |=> $stable(phase));

endmodule

// File: rtl/traffic_crossing_ctrl.sv
module traffic_crossing_ctrl
  import xing_pkg::*;
#(
  parameter int SHORT_TICKS = 3,
  parameter int LONG_TICKS  = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic farmCar,
  output logic hwyGreen,
  output logic hwyYellow,
  output logic hwyRed,
  output logic farmGreen,
  output logic farmYellow,
  output logic farmRed,
  output logic timerStart
);

  ctlStrobes_t strobes;
  tmrStatus_t  status;
  logic [2:0]  hwyLamps;
  logic [2:0]  farmLamps;

  xing_timer #(
    .SHORT_TICKS(SHORT_TICKS),
    .LONG_TICKS (LONG_TICKS)
  ) u_timer (
    .clk    (clk),
    .rst    (rst),
    .strobes(strobes),
    .status (status)
  );

  xing_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .farmCar  (farmCar),
    .status   (status),
    .strobes  (strobes),
    .hwyLamps (hwyLamps),
    .farmLamps(farmLamps)
  );

  assign {hwyGreen, hwyYellow, hwyRed}    = hwyLamps;
  assign {farmGreen, farmYellow, farmRed} = farmLamps;
  assign timerStart = strobes.restartTimer;

  assert_one_lamp_each_R6: assert property (@(posedge clk)
    $onehot({hwyGreen, hwyYellow, hwyRed}) && $onehot({farmGreen, farmYellow, farmRed}));

  assert_one_road_red_R6: assert property (@(posedge clk) hwyRed || farmRed);

  assert_reset_hwy_green_R1: assert property (@(posedge clk)
    rst |=> (hwyGreen && farmRed));

endmodule

// File: tb/traffic_crossing_ctrl_bench.sv
`timescale 1ns/1ps
module traffic_crossing_ctrl_bench;

  localparam int SHORT_T = 3;
  localparam int LONG_T  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic farmCar = 1'b0;
  logic hwyGreen, hwyYellow, hwyRed, farmGreen, farmYellow, farmRed, timerStart;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  // bench model: phase 0 hwy green, 1 hwy yellow, 2 farm green, 3 farm yellow
  int mPhase = 0;
  int mCount = 0;

  always #2.5 clk = ~clk;

  traffic_crossing_ctrl #(.SHORT_TICKS(SHORT_T), .LONG_TICKS(LONG_T)) u_traffic_crossing_ctrl (
    .clk(clk), .rst(rst), .farmCar(farmCar),
    .hwyGreen(hwyGreen), .hwyYellow(hwyYellow), .hwyRed(hwyRed),
    .farmGreen(farmGreen), .farmYellow(farmYellow), .farmRed(farmRed),
    .timerStart(timerStart)
  );

  function automatic int modelNext(int ph, bit car, int cnt);
    case (ph)
      0: return (car && cnt >= LONG_T) ? 1 : 0;
      1: return (cnt >= SHORT_T) ? 2 : 1;
      2: return (!car || cnt >= LONG_T) ? 3 : 2;
      default: return (cnt >= SHORT_T) ? 0 : 3;
    endcase
  endfunction

  function automatic logic [5:0] modelLamps(int ph);
    case (ph)
      0: return 6'b100_001;
      1: return 6'b010_001;
      2: return 6'b001_100;
      default: return 6'b001_010;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle: drive car, check lamps and strobe, clock, advance model
  task automatic stepCycle(bit car);
    int nxt;
    farmCar = car;
    #1;
    nxt = modelNext(mPhase, car, mCount);
    check((mPhase == 0) ? "R2 lamps" : (mPhase == 1) ? "R3 lamps" :
          (mPhase == 2) ? "R4 lamps" : "R5 lamps",
          {hwyGreen, hwyYellow, hwyRed, farmGreen, farmYellow, farmRed}, modelLamps(mPhase));
    check("R7 timerStart", timerStart, (nxt != mPhase));
    check("R6 one road red", (hwyRed | farmRed), 1);
    @(posedge clk);
    if (nxt != mPhase) mCount = 0;
    else if (mCount < LONG_T) mCount++;
    mPhase = nxt;
    @(negedge clk);
  endtask

  task automatic doReset();
    rst = 1'b1;
    farmCar = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 lamps in reset", {hwyGreen, hwyYellow, hwyRed, farmGreen, farmYellow, farmRed}, 6'b100_001);
    rst = 1'b0;
    mPhase = 0;
    mCount = 0;
  endtask

  // step with a fixed car value until the selected lamp lights; return steps
  task automatic measure(bit car, int sel, output int steps);
    logic lit;
    steps = 0;
    do begin
      stepCycle(car);
      steps++;
      case (sel)
        1: lit = hwyYellow;
        2: lit = farmGreen;
        3: lit = farmYellow;
        default: lit = hwyGreen;
      endcase
    end while (!lit && steps < 100);
  endtask

  initial begin
    int n;
    int unsigned seedVal;
    bit car;
    seedVal = $urandom(32'd4711);
    @(negedge clk);
    doReset();
    check("R1 hwy green after reset", {hwyGreen, farmRed}, 2'b11);

    // minimum highway green from reset, car waiting throughout
    measure(1'b1, 1, n);
    check("R2 min hwy green after reset", n, LONG_T + 1);
    measure(1'b1, 2, n);
    check("R3 hwy yellow length", n, SHORT_T + 1);
    measure(1'b1, 3, n);
    check("R4 farm green max length", n, LONG_T + 1);
    measure(1'b1, 0, n);
    check("R5 farm yellow length", n, SHORT_T + 1);

    // no car: highway green holds well past the long interval
    for (int i = 0; i < 3 * LONG_T; i++) stepCycle(1'b0);
    check("R2 hwy holds without car", hwyGreen, 1);

    // car appears late: leaves on the very next edge
    stepCycle(1'b1);
    check("R2 leave once car and long done", hwyYellow, 1);
    measure(1'b1, 2, n);
    // farm green cut after two cycles by car leaving
    stepCycle(1'b1);
    stepCycle(1'b1);
    measure(1'b0, 3, n);
    check("R4 farm green cut by no car", n, 1);
    measure(1'b0, 0, n);
    check("R5 back to hwy green", hwyGreen, 1);

    // immediate cut: car gone at first farm green cycle
    measure(1'b1, 2, n);
    measure(1'b0, 3, n);
    check("R4 farm green single cycle", n, 1);
    measure(1'b0, 0, n);

    // reset in the middle of a farm phase
    measure(1'b1, 2, n);
    doReset();
    measure(1'b1, 1, n);
    check("R1 min green applies after mid-run reset", n, LONG_T + 1);

    // random bursty traffic
    car = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 6) == 0) car = ~car;
      stepCycle(car);
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule